// File: doc/BRIEF.md
# Memory Size Probe Sequencer

This block discovers how much external memory is fitted behind a memory controller. After a start pulse it walks a fixed list of five candidate bank layouts, biggest first (128, 64, 32, 16 and 4 MiB). For each one it programs the controller through a register-write port, lets the memory settle, turns the controller on, settles again and asks an external size tester to measure a window of the candidate size at address zero. The first candidate whose measured size matches is kept.

When the optional second-bank input is high at start, a match is followed by a second round. The block programs bank 1 as an identical copy placed directly above bank 0 and tests it at a base address equal to the bank size. If that test fails, bank 1 and the controller are switched off again and only one bank is counted; otherwise the reported size is twice the bank size. The result is either the total size or zero when no candidate matched. It is presented together with a one-cycle done pulse.

Wait lengths are set in microseconds and scaled by a clock-cycles-per-microsecond parameter. The controller register contents for timing and refresh are parameters.

Top module: `mem_size_probe`

## Requirements
- R1: After reset, busy, done, rw_valid and test_req are all low.
- R2: Candidates are tried in the order 128, 64, 32, 16, 4 MiB with bank configuration words 0x000A4001, 0x00084001, 0x00062001, 0x00046001 and 0x00008001 respectively. Each bank-0 test requests base 0 and a span equal to the candidate size, and holds the request, base and span stable until test_ack.
- R3: For each candidate the write port issues, in this order: address 0 (controller control) with 0, address 1 (bank 0) with the configuration word, address 3 (timing) with TIMING_WORD, address 4 (refresh) with REFRESH_WORD, and address 0 with 0x80800000 (enable). A write is never issued while a test is requested.
- R4: Between the refresh write and the enable write there are exactly PRE_US*CYC_PER_US idle cycles when rw_ready stays high.
- R5: Between the enable write and the rising edge of test_req there are exactly POST_US*CYC_PER_US idle cycles.
- R6: The first candidate whose test_size equals its size ends the walk. With second-bank mode off, size_o equals that size, and done is high for exactly one cycle.
- R7: If no candidate matches, size_o is 0 after exactly five tests.
- R8: In second-bank mode a bank-0 match is followed by the writes address 0 with 0, address 2 (bank 1) with size OR configuration word, and address 0 with 0x80800000. A wait of POST_US*CYC_PER_US cycles then follows, and then a test at base = size and span = size.
- R9: If the bank-1 test fails, the writes address 2 with 0 and then address 0 with 0 follow, and size_o is the single bank size. If it passes, size_o is twice the bank size with no further writes.
- R10: While rw_ready is low, rw_valid, rw_addr and rw_data hold their values, and the sequence continues unchanged once ready returns.
- R11: A start pulse while busy is high has no effect on the sequence or result.
- R12: busy is high from the cycle after an accepted start until done, and falls in the same cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a probe when idle |
| second_bank_en | input | 1 | Sampled at start; enables the bank-1 round |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse, size_o valid |
| size_o | output | 32 | Detected total size in bytes, 0 if none |
| rw_valid | output | 1 | Register write request |
| rw_ready | input | 1 | Controller accepts the write this cycle |
| rw_addr | output | 4 | Register address |
| rw_data | output | 32 | Register write data |
| test_req | output | 1 | Size test request, held until ack |
| test_ack | input | 1 | Size test complete, test_size valid |
| test_base | output | 32 | Base byte address for the test |
| test_span | output | 32 | Expected size for the test |
| test_size | input | 32 | Measured size |

## Verification
A write is taken in the cycle where the bench sees rw_valid and rw_ready together at the falling edge. The next step is visible at the following falling edge. The enable write therefore appears PRE_US*CYC_PER_US+1 cycles after the refresh write, and test_req rises POST_US*CYC_PER_US+1 cycles after an enable write. The bench records the cycle number of every accepted write and test request and compares these distances exactly. The responder answers three falling edges after test_req rises. done and size_o are read at the falling edge after the edge that consumed the last ack or write.

// File: rtl/msp_pkg.sv
// Shared constants, types and candidate list for the memory size probe.
// Assumes 32-bit byte sizes and a 4-bit register address space.
package msp_pkg;

    localparam int SIZE_W   = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int NUM_CAND = 5;
    localparam int IDX_W    = $clog2(NUM_CAND);

    // Register addresses on the write port
    localparam logic [ADDR_W-1:0] RA_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] RA_BANK0   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_BANK1   = 4'd2;
    localparam logic [ADDR_W-1:0] RA_TIMING  = 4'd3;
    localparam logic [ADDR_W-1:0] RA_REFRESH = 4'd4;

    localparam logic [DATA_W-1:0] CTRL_ON = 32'h8080_0000;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] cfg;
    } cand_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OFF, ST_BANK0, ST_TIMING, ST_REFR, ST_PRE, ST_ON,
        ST_POST, ST_TEST, ST_B1_OFF, ST_B1_CFG, ST_B1_ON, ST_B1_POST,
        ST_B1_TEST, ST_B1_CLR, ST_B1_OFF2
    } state_e;

    // Candidate layout for a table index, largest first
    function automatic cand_t cand_lookup(input logic [IDX_W-1:0] idx);
        cand_t c;
        case (idx)
            3'd0:    begin c.size = 32'd128 << 20; c.cfg = 32'h000A_4001; end
            3'd1:    begin c.size = 32'd64  << 20; c.cfg = 32'h0008_4001; end
            3'd2:    begin c.size = 32'd32  << 20; c.cfg = 32'h0006_2001; end
            3'd3:    begin c.size = 32'd16  << 20; c.cfg = 32'h0004_6001; end
            default: begin c.size = 32'd4   << 20; c.cfg = 32'h0000_8001; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/msp_wait_timer.sv
// Down-counting settle timer. A load of N keeps expired low for N-1
// cycles, so a state that waits on expired lasts exactly N cycles.
// Assumes load values of at least 1.
module msp_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Final cycle of the wait
    always_comb expired = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/msp_step_decode.sv
// Maps the sequencer state to the register write it must present.
// Purely combinational; the sequencer holds the state while stalled.
module msp_step_decode
    import msp_pkg::*;
(
    input  state_e              st,
    input  cand_t               cand,
    input  logic [DATA_W-1:0]   timing_word,
    input  logic [DATA_W-1:0]   refresh_word,
    output logic                wr_valid,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data
);
    // Address and data per write step
    always_comb begin
        wr_valid = 1'b1;
        wr_addr  = RA_CTRL;
        wr_data  = '0;
        case (st)
            ST_OFF, ST_B1_OFF, ST_B1_OFF2: begin
                wr_addr = RA_CTRL;    wr_data = '0;
            end
            ST_BANK0:  begin wr_addr = RA_BANK0;   wr_data = cand.cfg;           end
            ST_TIMING: begin wr_addr = RA_TIMING;  wr_data = timing_word;        end
            ST_REFR:   begin wr_addr = RA_REFRESH; wr_data = refresh_word;       end
            ST_ON, ST_B1_ON: begin
                wr_addr = RA_CTRL;    wr_data = CTRL_ON;
            end
            ST_B1_CFG: begin wr_addr = RA_BANK1;   wr_data = cand.size | cand.cfg; end
            ST_B1_CLR: begin wr_addr = RA_BANK1;   wr_data = '0;                 end
            default:   begin wr_valid = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mem_size_probe.sv
// Memory size probe sequencer. Walks the candidate list largest first,
// programs the controller for each layout, waits, enables, waits, and
// requests a size test. Optionally adds a second identical bank.
// Assumes the size tester holds test_ack for one cycle per request.
module mem_size_probe
    import msp_pkg::*;
#(
    parameter int                CYC_PER_US   = 100,
    parameter int                PRE_US       = 200,
    parameter int                POST_US      = 10000,
    parameter logic [DATA_W-1:0] TIMING_WORD  = 32'h0086_400D,
    parameter logic [DATA_W-1:0] REFRESH_WORD = 32'h05F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              second_bank_en,
    output logic              busy,
    output logic              done,
    output logic [SIZE_W-1:0] size_o,
    output logic              rw_valid,
    input  logic              rw_ready,
    output logic [ADDR_W-1:0] rw_addr,
    output logic [DATA_W-1:0] rw_data,
    output logic              test_req,
    input  logic              test_ack,
    output logic [SIZE_W-1:0] test_base,
    output logic [SIZE_W-1:0] test_span,
    input  logic [SIZE_W-1:0] test_size
);
    localparam int PRE_CYC  = PRE_US * CYC_PER_US;
    localparam int POST_CYC = POST_US * CYC_PER_US;
    localparam int MAX_CYC  = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAND - 1);

    state_e            state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              dual_q;
    logic              done_q;
    logic [SIZE_W-1:0] size_q;
    cand_t             cand;

    logic              idx_clr, idx_inc, finish;
    logic [SIZE_W-1:0] fin_val;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic              wr_accept;

    // Candidate of the current step
    always_comb cand = cand_lookup(idx_q);

    msp_step_decode u_dec (
        .st           (state_q),
        .cand         (cand),
        .timing_word  (TIMING_WORD),
        .refresh_word (REFRESH_WORD),
        .wr_valid     (rw_valid),
        .wr_addr      (rw_addr),
        .wr_data      (rw_data)
    );

    msp_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb wr_accept = rw_valid && rw_ready;

    // Next state, table walk and result decisions
    always_comb begin
        state_d  = state_q;
        idx_clr  = 1'b0;
        idx_inc  = 1'b0;
        finish   = 1'b0;
        fin_val  = '0;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(POST_CYC);
        case (state_q)
            ST_IDLE: if (start) begin state_d = ST_OFF; idx_clr = 1'b1; end
            ST_OFF:    if (wr_accept) state_d = ST_BANK0;
            ST_BANK0:  if (wr_accept) state_d = ST_TIMING;
            ST_TIMING: if (wr_accept) state_d = ST_REFR;
            ST_REFR: if (wr_accept) begin
                state_d  = ST_PRE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PRE_CYC);
            end
            ST_PRE: if (tmr_exp) state_d = ST_ON;
            ST_ON: if (wr_accept) begin state_d = ST_POST; tmr_load = 1'b1; end
            ST_POST: if (tmr_exp) state_d = ST_TEST;
            ST_TEST: if (test_ack) begin
                if (test_size == cand.size) begin
                    if (dual_q) state_d = ST_B1_OFF;
                    else begin
                        state_d = ST_IDLE; finish = 1'b1; fin_val = cand.size;
                    end
                end else if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE; finish = 1'b1; fin_val = '0;
                end else begin
                    state_d = ST_OFF; idx_inc = 1'b1;
                end
            end
            ST_B1_OFF: if (wr_accept) state_d = ST_B1_CFG;
            ST_B1_CFG: if (wr_accept) state_d = ST_B1_ON;
            ST_B1_ON: if (wr_accept) begin state_d = ST_B1_POST; tmr_load = 1'b1; end
            ST_B1_POST: if (tmr_exp) state_d = ST_B1_TEST;
            ST_B1_TEST: if (test_ack) begin
                if (test_size == cand.size) begin
                    state_d = ST_IDLE; finish = 1'b1;
                    fin_val = {cand.size[SIZE_W-2:0], 1'b0};
                end else state_d = ST_B1_CLR;
            end
            ST_B1_CLR: if (wr_accept) state_d = ST_B1_OFF2;
            ST_B1_OFF2: if (wr_accept) begin
                state_d = ST_IDLE; finish = 1'b1; fin_val = cand.size;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, index, mode latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            dual_q  <= 1'b0;
            done_q  <= 1'b0;
            size_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (idx_clr) begin
                idx_q  <= '0;
                dual_q <= second_bank_en;
            end else if (idx_inc) begin
                idx_q  <= idx_q + 1'b1;
            end
            if (finish) size_q <= fin_val;
        end
    end

    // Output drive for status and the test port
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        size_o    = size_q;
        test_req  = (state_q == ST_TEST) || (state_q == ST_B1_TEST);
        test_base = (state_q == ST_B1_TEST) ? cand.size : '0;
        test_span = cand.size;
    end
endmodule

// File: rtl/msp_checker.sv
// Protocol checker for mem_size_probe, attached with bind below.
module msp_checker
    import msp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [SIZE_W-1:0] size_o,
    input logic              rw_valid,
    input logic              rw_ready,
    input logic [ADDR_W-1:0] rw_addr,
    input logic [DATA_W-1:0] rw_data,
    input logic              test_req,
    input logic              test_ack,
    input logic [SIZE_W-1:0] test_base,
    input logic [SIZE_W-1:0] test_span
);
    // R10: a stalled write holds its address and data
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid && !rw_ready |=> rw_valid && $stable(rw_addr) && $stable(rw_data));

    // R2: an open test request holds base and span
    a_r2_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
        test_req && !test_ack |=> test_req && $stable(test_base) && $stable(test_span));

    // R3: writes and tests never overlap
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid |-> !test_req);

    // R12: port activity only while busy
    a_r12_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_valid || test_req) |-> busy);

    // R12: busy falls together with done
    a_r12_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result is zero or a single power of two
    a_r7_result_shape: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(size_o) <= 1) && !busy);
endmodule

bind mem_size_probe msp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .size_o    (size_o),
    .rw_valid  (rw_valid),
    .rw_ready  (rw_ready),
    .rw_addr   (rw_addr),
    .rw_data   (rw_data),
    .test_req  (test_req),
    .test_ack  (test_ack),
    .test_base (test_base),
    .test_span (test_span)
);

// File: tb/mem_size_probe_tb.sv
// Directed bench for mem_size_probe: one task per scenario.
module mem_size_probe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int PRE   = 5;
    localparam int POST  = 20;
    localparam int PRE_C = PRE * CPU;
    localparam int POST_C = POST * CPU;
    localparam logic [31:0] TW = 32'h1234_5678;
    localparam logic [31:0] RW = 32'h0ABC_0000;
    localparam logic [31:0] MB = 32'd1 << 20;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dual = 1'b0;
    logic busy, done, rw_valid, test_req;
    logic rw_ready = 1'b1, test_ack = 1'b0;
    logic [3:0]  rw_addr;
    logic [31:0] rw_data, size_o, test_base, test_span;
    logic [31:0] test_size = '0;

    int checks = 0, failures = 0, cyc = 0;
    logic [31:0] inst0 = '0, inst1 = '0;
    logic stall = 1'b0;
    int resp_wait = 0;
    logic prev_req = 1'b0;
    int wn = 0, tn = 0;
    logic [3:0]  w_addr [64];
    logic [31:0] w_data [64];
    int          w_cyc  [64];
    logic [31:0] t_base [16];
    logic [31:0] t_span [16];
    int          t_cyc  [16];

    mem_size_probe #(.CYC_PER_US(CPU), .PRE_US(PRE), .POST_US(POST),
                     .TIMING_WORD(TW), .REFRESH_WORD(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .second_bank_en(dual),
        .busy(busy), .done(done), .size_o(size_o),
        .rw_valid(rw_valid), .rw_ready(rw_ready), .rw_addr(rw_addr),
        .rw_data(rw_data), .test_req(test_req), .test_ack(test_ack),
        .test_base(test_base), .test_span(test_span), .test_size(test_size));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] exp_size(int i);
        return (i == 4) ? 4 * MB : (128 * MB) >> i;
    endfunction
    function automatic logic [31:0] exp_cfg(int i);
        case (i)
            0: return 32'h000A_4001;
            1: return 32'h0008_4001;
            2: return 32'h0006_2001;
            3: return 32'h0004_6001;
            default: return 32'h0000_8001;
        endcase
    endfunction

    // Ready pattern, size-test responder, then logging of accepted steps
    always @(negedge clk) begin
        rw_ready = stall ? (cyc % 3 == 0) : 1'b1;
        if (test_ack) test_ack = 1'b0;
        else if (test_req) begin
            if (resp_wait == 2) begin
                logic [31:0] bank;
                bank = (test_base == 0) ? inst0 : inst1;
                test_size = (bank >= test_span) ? test_span : bank;
                test_ack = 1'b1;
                resp_wait = 0;
            end else resp_wait++;
        end
        if (rw_valid && rw_ready && wn < 64) begin
            w_addr[wn] = rw_addr; w_data[wn] = rw_data; w_cyc[wn] = cyc; wn++;
        end
        if (test_req && !prev_req && tn < 16) begin
            t_base[tn] = test_base; t_span[tn] = test_span; t_cyc[tn] = cyc; tn++;
        end
        prev_req = test_req;
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Runs one probe; optional second start pulse part-way through
    task automatic run_probe(logic [31:0] b0, logic [31:0] b1, logic d,
                             bit extra_start, output logic [31:0] res);
        int t = 0;
        int busy_low = 0;
        inst0 = b0; inst1 = b1; dual = d; wn = 0; tn = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && t < 20000) begin
            if (!busy) busy_low++;
            if (extra_start && t == 30) start = 1'b1;
            else start = 1'b0;
            @(negedge clk); t++;
        end
        start = 1'b0;
        chk("R12", "busy low cycles during probe", busy_low, 0);
        chk("R12", "busy at done", busy, 0);
        chk("R6", "done seen", done, 1);
        res = size_o;
        @(negedge clk);
        chk("R6", "done one cycle", done, 0);
    endtask

    // Checks the five writes of candidate i starting at log entry k
    task automatic chk_cand_writes(int k, int i, string req);
        chk(req, "ctrl off addr", w_addr[k], 0);
        chk(req, "ctrl off data", w_data[k], 0);
        chk("R2", "bank0 addr", w_addr[k+1], 1);
        chk("R2", "bank0 cfg", w_data[k+1], exp_cfg(i));
        chk(req, "timing addr", w_addr[k+2], 3);
        chk(req, "timing data", w_data[k+2], TW);
        chk(req, "refresh addr", w_addr[k+3], 4);
        chk(req, "refresh data", w_data[k+3], RW);
        chk(req, "enable addr", w_addr[k+4], 0);
        chk(req, "enable data", w_data[k+4], 32'h8080_0000);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rw_valid", rw_valid, 0);
        chk("R1", "test_req", test_req, 0);
    endtask

    task automatic t_full();
        logic [31:0] r;
        run_probe(256 * MB, 0, 1'b0, 1'b0, r);
        chk("R6", "result 128MiB", r, 128 * MB);
        chk("R3", "write count", wn, 5);
        chk_cand_writes(0, 0, "R3");
        chk("R2", "test count", tn, 1);
        chk("R2", "test base", t_base[0], 0);
        chk("R2", "test span", t_span[0], 128 * MB);
        chk("R4", "pre-enable gap", w_cyc[4] - w_cyc[3], PRE_C + 1);
        chk("R5", "post-enable gap", t_cyc[0] - w_cyc[4], POST_C + 1);
    endtask

    task automatic t_walk16();
        logic [31:0] r;
        run_probe(16 * MB, 0, 1'b0, 1'b0, r);
        chk("R6", "result 16MiB", r, 16 * MB);
        chk("R2", "test count", tn, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2", "walk span", t_span[i], exp_size(i));
            chk("R2", "walk base", t_base[i], 0);
            chk_cand_writes(5 * i, i, "R3");
        end
    endtask

    task automatic t_none();
        logic [31:0] r;
        run_probe(2 * MB, 0, 1'b0, 1'b0, r);
        chk("R7", "result zero", r, 0);
        chk("R7", "five tests", tn, 5);
        chk("R7", "last span 4MiB", t_span[4], 4 * MB);
        chk("R7", "write count", wn, 25);
    endtask

    task automatic t_dual_ok();
        logic [31:0] r;
        run_probe(32 * MB, 32 * MB, 1'b1, 1'b0, r);
        chk("R9", "doubled result", r, 64 * MB);
        chk("R8", "write count", wn, 18);
        chk("R8", "b1 off addr", w_addr[15], 0);
        chk("R8", "b1 off data", w_data[15], 0);
        chk("R8", "bank1 addr", w_addr[16], 2);
        chk("R8", "bank1 data", w_data[16], 32 * MB | 32'h0006_2001);
        chk("R8", "b1 on addr", w_addr[17], 0);
        chk("R8", "b1 on data", w_data[17], 32'h8080_0000);
        chk("R8", "test count", tn, 4);
        chk("R8", "bank1 base", t_base[3], 32 * MB);
        chk("R8", "bank1 span", t_span[3], 32 * MB);
        chk("R8", "bank1 wait", t_cyc[3] - w_cyc[17], POST_C + 1);
    endtask

    task automatic t_dual_fail();
        logic [31:0] r;
        run_probe(64 * MB, 8 * MB, 1'b1, 1'b0, r);
        chk("R9", "single bank result", r, 64 * MB);
        chk("R9", "write count", wn, 15);
        chk("R9", "clear bank1 addr", w_addr[13], 2);
        chk("R9", "clear bank1 data", w_data[13], 0);
        chk("R9", "clear ctrl addr", w_addr[14], 0);
        chk("R9", "clear ctrl data", w_data[14], 0);
    endtask

    task automatic t_stall_restart();
        logic [31:0] r;
        stall = 1'b1;
        run_probe(64 * MB, 0, 1'b0, 1'b1, r);
        stall = 1'b0;
        chk("R10", "result under stalls", r, 64 * MB);
        chk("R10", "write count", wn, 10);
        chk_cand_writes(0, 0, "R10");
        chk_cand_writes(5, 1, "R10");
        chk("R11", "tests with stray start", tn, 2);
        repeat (5) @(negedge clk);
        chk("R11", "idle after run", busy, 0);
        chk("R11", "no extra writes", wn, 10);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_walk16();
        t_none();
        t_dual_ok();
        t_dual_fail();
        t_stall_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule